// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block puts a processor core into a low-power sleep state and brings it back. When the core reports a sleep instruction, the block does one of two things. If an enabled interrupt is already waiting, the sleep becomes a no-op. Otherwise it stops the main oscillator, stalls the core and freezes the I/O outputs. It also clears the watchdog and updates the power-down and time-out status bits. The block then waits for a wake event. A wake event is an interrupt source whose flag and enable are both set, or a watchdog time-out.

On a wake event the block restarts the oscillator and clears the watchdog again. It keeps the core stalled for a fixed oscillator start-up delay. It then releases the core with a one-cycle resume strobe. With that strobe it tells the core whether to run on from the prefetched next instruction or to branch to the interrupt vector after that instruction.

A synchronous power-on reset initialises everything, including the status bits. An external reset input returns the controller to the running state and leaves the status bits untouched.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While `por` is high, and at the first clock after it falls, the outputs are: `pd_bit`=1, `to_bit`=1, `osc_en`=1, `core_stall`=0, `io_hold`=0, `wdt_clr`=0, `resume`=0, `take_vector`=0, `branch_addr`=0.
- R2: Take a cycle in which the controller is running, `sleep_op`=1, and no bit i has both `irq_flag[i]` and `irq_en[i]` set. The clock edge ending that cycle enters sleep. It sets `pd_bit`=0, `to_bit`=1, `osc_en`=0, `core_stall`=1 and `io_hold`=1. It also raises `wdt_clr` for exactly one cycle.
- R3: Take a cycle in which the controller is running, `sleep_op`=1, and some bit has both its flag and its enable set. That sleep strobe is a no-op. `pd_bit`, `to_bit` and `osc_en` keep their values, `wdt_clr` stays 0, and `core_stall` stays 0.
- R4: While asleep, a source wakes the block only if its flag and its enable are both set. A flag whose enable is clear has no effect, and the value of `gie` does not decide whether a wake happens.
- R5: An interrupt wake happens on the edge after a cycle asleep with a flag-and-enable match. That edge sets `osc_en`=1 and pulses `wdt_clr` for one cycle. `core_stall` stays 1 for STARTUP cycles counted from that edge, and `pd_bit` and `to_bit` are unchanged.
- R6: A `wdt_timeout` pulse while asleep wakes the block. It clears `to_bit` and pulses `wdt_clr`, then follows the same start-up delay as R5.
- R7: STARTUP edges after the wake edge, `core_stall` and `io_hold` fall and `resume` is 1 for one cycle. In that same cycle, `take_vector`=1 and `branch_addr`=VEC_ADDR (0x0004 by default) if an interrupt match was present and `gie`=1 on the wake edge. Otherwise `take_vector`=0 and `branch_addr`=0, and both are 0 outside the resume cycle.
- R8: `ext_rst`=1 (with `por`=0) returns the controller to running on the next edge. It sets `osc_en`=1, `core_stall`=0, `io_hold`=0 and `resume`=0, and leaves `pd_bit` and `to_bit` unchanged.
- R9: `sleep_op` has no effect while the controller is asleep or waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous active-high power-on reset |
| ext_rst | input | 1 | External reset: back to running, status bits kept |
| sleep_op | input | 1 | One-cycle strobe: the core executes a sleep instruction |
| irq_flag | input | N | Per-source interrupt flags |
| irq_en | input | N | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable, sampled on the wake edge |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| osc_en | output | 1 | Main oscillator driver enable |
| wdt_clr | output | 1 | One-cycle watchdog clear pulse |
| core_stall | output | 1 | Holds the core while asleep or waking |
| io_hold | output | 1 | Freezes the I/O output values and drive state |
| pd_bit | output | 1 | Power-down status bit |
| to_bit | output | 1 | Time-out status bit |
| resume | output | 1 | One-cycle strobe: the core restarts |
| take_vector | output | 1 | With `resume`: branch to the vector after the next instruction |
| branch_addr | output | AW | Vector address during a vectoring resume, else 0 |

## Verification
The properties assume that every input is synchronous to `clk` and free of X, and that `por` overrides all other inputs. The bench drives inputs one time unit after each rising edge, so each input is stable across the edge that samples it. Random stimulus keeps `sleep_op` and `wdt_timeout` sparse, so sleeps, no-op sleeps, masked flags and both wake causes all occur. It fires `ext_rst` and `por` rarely, so both resets land in every state without hiding the start-up count.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } swc_state_e;
endpackage

// File: rtl/swc_wake_detect.sv
module swc_wake_detect #(
  parameter int N = 8
) (
  input  logic [N-1:0] irq_flag,
  input  logic [N-1:0] irq_en,
  output logic         pending
);
  logic [N-1:0] hit;

  // A source counts only when its own enable is set.
  for (genvar i = 0; i < N; i++) begin : g_src
    assign hit[i] = irq_flag[i] & irq_en[i];
  end

  assign pending = |hit;
endmodule

// File: rtl/swc_startup_timer.sv
module swc_startup_timer #(
  parameter int STARTUP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (STARTUP > 1) ? $clog2(STARTUP) : 1;
  localparam logic [CW-1:0] LAST = CW'(STARTUP - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!done)  cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);
endmodule

// File: rtl/swc_ctrl_fsm.sv
module swc_ctrl_fsm
  import swc_pkg::*;
#(
  parameter int            AW       = 13,
  parameter logic [AW-1:0] VEC_ADDR = AW'(4)
) (
  input  logic          clk,
  input  logic          por,
  input  logic          ext_rst,
  input  logic          sleep_op,
  input  logic          pending,
  input  logic          gie,
  input  logic          wdt_timeout,
  input  logic          su_done,
  output swc_state_e    state,
  output logic          osc_en,
  output logic          wdt_clr,
  output logic          core_stall,
  output logic          io_hold,
  output logic          pd_bit,
  output logic          to_bit,
  output logic          resume,
  output logic          take_vector,
  output logic [AW-1:0] branch_addr
);
  logic vec_pend;

  always_ff @(posedge clk) begin
    if (por) begin
      state       <= ST_RUN;
      pd_bit      <= 1'b1;
      to_bit      <= 1'b1;
      osc_en      <= 1'b1;
      wdt_clr     <= 1'b0;
      core_stall  <= 1'b0;
      io_hold     <= 1'b0;
      resume      <= 1'b0;
      take_vector <= 1'b0;
      branch_addr <= '0;
      vec_pend    <= 1'b0;
    end else begin
      wdt_clr     <= 1'b0;
      resume      <= 1'b0;
      take_vector <= 1'b0;
      branch_addr <= '0;
      if (ext_rst) begin
        state      <= ST_RUN;
        osc_en     <= 1'b1;
        core_stall <= 1'b0;
        io_hold    <= 1'b0;
      end else begin
        unique case (state)
          ST_RUN: begin
            // A pending enabled source turns the sleep into a no-op.
            if (sleep_op && !pending) begin
              state      <= ST_SLEEP;
              pd_bit     <= 1'b0;
              to_bit     <= 1'b1;
              wdt_clr    <= 1'b1;
              osc_en     <= 1'b0;
              core_stall <= 1'b1;
              io_hold    <= 1'b1;
            end
          end
          ST_SLEEP: begin
            if (pending || wdt_timeout) begin
              state    <= ST_WAKE;
              wdt_clr  <= 1'b1;
              osc_en   <= 1'b1;
              vec_pend <= pending & gie;
              if (wdt_timeout) to_bit <= 1'b0;
            end
          end
          ST_WAKE: begin
            if (su_done) begin
              state       <= ST_RUN;
              core_stall  <= 1'b0;
              io_hold     <= 1'b0;
              resume      <= 1'b1;
              take_vector <= vec_pend;
              branch_addr <= vec_pend ? VEC_ADDR : '0;
            end
          end
          default: state <= ST_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int            N        = 8,
  parameter int            STARTUP  = 4,
  parameter int            AW       = 13,
  parameter logic [AW-1:0] VEC_ADDR = AW'(4)
) (
  input  logic          clk,
  input  logic          por,
  input  logic          ext_rst,
  input  logic          sleep_op,
  input  logic [N-1:0]  irq_flag,
  input  logic [N-1:0]  irq_en,
  input  logic          gie,
  input  logic          wdt_timeout,
  output logic          osc_en,
  output logic          wdt_clr,
  output logic          core_stall,
  output logic          io_hold,
  output logic          pd_bit,
  output logic          to_bit,
  output logic          resume,
  output logic          take_vector,
  output logic [AW-1:0] branch_addr
);
  swc_state_e state;
  logic       pending;
  logic       su_done;

  swc_wake_detect #(.N(N)) u_detect (
    .irq_flag (irq_flag),
    .irq_en   (irq_en),
    .pending  (pending)
  );

  swc_startup_timer #(.STARTUP(STARTUP)) u_timer (
    .clk  (clk),
    .rst  (por | ext_rst),
    .run  (state == ST_WAKE),
    .done (su_done)
  );

  swc_ctrl_fsm #(.AW(AW), .VEC_ADDR(VEC_ADDR)) u_fsm (
    .clk         (clk),
    .por         (por),
    .ext_rst     (ext_rst),
    .sleep_op    (sleep_op),
    .pending     (pending),
    .gie         (gie),
    .wdt_timeout (wdt_timeout),
    .su_done     (su_done),
    .state       (state),
    .osc_en      (osc_en),
    .wdt_clr     (wdt_clr),
    .core_stall  (core_stall),
    .io_hold     (io_hold),
    .pd_bit      (pd_bit),
    .to_bit      (to_bit),
    .resume      (resume),
    .take_vector (take_vector),
    .branch_addr (branch_addr)
  );
endmodule

// File: rtl/swc_checker.sv
module swc_checker
  import swc_pkg::*;
#(
  parameter int N = 8
) (
  input logic         clk,
  input logic         por,
  input logic         ext_rst,
  input logic         sleep_op,
  input logic [N-1:0] irq_flag,
  input logic [N-1:0] irq_en,
  input logic         wdt_timeout,
  input swc_state_e   state,
  input logic         osc_en,
  input logic         wdt_clr,
  input logic         core_stall,
  input logic         io_hold,
  input logic         pd_bit,
  input logic         to_bit,
  input logic         resume,
  input logic         take_vector
);
  logic pend;
  assign pend = |(irq_flag & irq_en);

  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (por)
    (state == ST_RUN && sleep_op && !pend && !ext_rst) |=>
      (state == ST_SLEEP && !pd_bit && to_bit && wdt_clr && !osc_en && core_stall && io_hold));

  p_noop_sleep_r3: assert property (@(posedge clk) disable iff (por)
    (state == ST_RUN && sleep_op && pend && !ext_rst) |=>
      ($stable(pd_bit) && $stable(to_bit) && !wdt_clr && osc_en && !core_stall));

  p_masked_stays_r4: assert property (@(posedge clk) disable iff (por)
    (state == ST_SLEEP && !pend && !wdt_timeout && !ext_rst) |=>
      (state == ST_SLEEP && !osc_en && core_stall));

  p_int_wake_r5: assert property (@(posedge clk) disable iff (por)
    (state == ST_SLEEP && pend && !ext_rst) |=>
      (state == ST_WAKE && wdt_clr && osc_en && core_stall && $stable(pd_bit)));

  p_wdt_wake_r6: assert property (@(posedge clk) disable iff (por)
    (state == ST_SLEEP && wdt_timeout && !ext_rst) |=> (!to_bit && wdt_clr && osc_en));

  p_resume_released_r7: assert property (@(posedge clk) disable iff (por)
    resume |-> (state == ST_RUN && !core_stall && !io_hold && osc_en));

  p_vector_with_resume_r7: assert property (@(posedge clk) disable iff (por)
    take_vector |-> resume);

  p_ext_reset_r8: assert property (@(posedge clk) disable iff (por)
    ext_rst |=> (state == ST_RUN && $stable(pd_bit) && $stable(to_bit) &&
                 !core_stall && osc_en && !resume));
endmodule

bind sleep_wake_ctrl swc_checker #(.N(N)) u_chk (
  .clk         (clk),
  .por         (por),
  .ext_rst     (ext_rst),
  .sleep_op    (sleep_op),
  .irq_flag    (irq_flag),
  .irq_en      (irq_en),
  .wdt_timeout (wdt_timeout),
  .state       (state),
  .osc_en      (osc_en),
  .wdt_clr     (wdt_clr),
  .core_stall  (core_stall),
  .io_hold     (io_hold),
  .pd_bit      (pd_bit),
  .to_bit      (to_bit),
  .resume      (resume),
  .take_vector (take_vector)
);

// File: tb/sleep_wake_ctrl_test.sv
module sleep_wake_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int SU = 4;
  localparam int AW = 13;
  localparam logic [AW-1:0] VEC = 13'h0004;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          por = 1'b1, ext_rst = 1'b0, sleep_op = 1'b0, gie = 1'b0, wdt_timeout = 1'b0;
  logic [N-1:0]  irq_flag = '0, irq_en = '0;
  logic          osc_en, wdt_clr, core_stall, io_hold, pd_bit, to_bit, resume, take_vector;
  logic [AW-1:0] branch_addr;

  sleep_wake_ctrl #(.N(N), .STARTUP(SU), .AW(AW), .VEC_ADDR(VEC)) uut (
    .clk(clk), .por(por), .ext_rst(ext_rst), .sleep_op(sleep_op),
    .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie), .wdt_timeout(wdt_timeout),
    .osc_en(osc_en), .wdt_clr(wdt_clr), .core_stall(core_stall), .io_hold(io_hold),
    .pd_bit(pd_bit), .to_bit(to_bit), .resume(resume), .take_vector(take_vector),
    .branch_addr(branch_addr)
  );

  int checks = 0;
  int errors = 0;

  // Expected-value model built from the requirements (0 run, 1 asleep, 2 waking).
  int            e_st, e_cnt;
  logic          e_pd, e_to, e_osc, e_clr, e_stall, e_hold, e_res, e_tv, e_vec;
  logic [AW-1:0] e_addr;

  function automatic logic match(input logic [N-1:0] f, input logic [N-1:0] e);
    return |(f & e);
  endfunction

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkw(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic p;
    p = match(irq_flag, irq_en);
    if (por) begin
      e_st = 0; e_cnt = 0; e_pd = 1; e_to = 1; e_osc = 1; e_clr = 0;
      e_stall = 0; e_hold = 0; e_res = 0; e_tv = 0; e_addr = '0; e_vec = 0;
    end else begin
      e_clr = 0; e_res = 0; e_tv = 0; e_addr = '0;
      if (ext_rst) begin
        e_st = 0; e_cnt = 0; e_osc = 1; e_stall = 0; e_hold = 0;
      end else if (e_st == 0) begin
        if (sleep_op && !p) begin
          e_st = 1; e_pd = 0; e_to = 1; e_clr = 1; e_osc = 0; e_stall = 1; e_hold = 1;
        end
      end else if (e_st == 1) begin
        if (p || wdt_timeout) begin
          e_st = 2; e_cnt = 0; e_clr = 1; e_osc = 1; e_vec = p & gie;
          if (wdt_timeout) e_to = 0;
        end
      end else begin
        if (e_cnt == SU - 1) begin
          e_st = 0; e_cnt = 0; e_stall = 0; e_hold = 0; e_res = 1; e_tv = e_vec;
          e_addr = e_vec ? VEC : '0;
        end else e_cnt++;
      end
    end
  endtask

  // One clock: update the model from the inputs, then sample 1 unit after the edge.
  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    chk1("R2 pd_bit model", pd_bit, e_pd);
    chk1("R6 to_bit model", to_bit, e_to);
    chk1("R2 wdt_clr model", wdt_clr, e_clr);
    chk1("R5 osc_en model", osc_en, e_osc);
    chk1("R5 core_stall model", core_stall, e_stall);
    chk1("R2 io_hold model", io_hold, e_hold);
    chk1("R7 resume model", resume, e_res);
    chk1("R7 take_vector model", take_vector, e_tv);
    chkw("R7 branch_addr model", branch_addr, e_addr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(20240611);
    #1;
    repeat (3) tick();
    // R1 reset state
    chk1("R1 pd_bit", pd_bit, 1'b1);
    chk1("R1 to_bit", to_bit, 1'b1);
    chk1("R1 osc_en", osc_en, 1'b1);
    chk1("R1 core_stall", core_stall, 1'b0);
    chk1("R1 io_hold", io_hold, 1'b0);
    chk1("R1 resume", resume, 1'b0);
    por = 1'b0;
    tick();
    chk1("R1 wdt_clr", wdt_clr, 1'b0);

    // R2 sleep entry
    irq_en = 8'h01; irq_flag = 8'h00; sleep_op = 1'b1;
    tick();
    sleep_op = 1'b0;
    chk1("R2 pd_bit", pd_bit, 1'b0);
    chk1("R2 to_bit", to_bit, 1'b1);
    chk1("R2 wdt_clr", wdt_clr, 1'b1);
    chk1("R2 osc_en", osc_en, 1'b0);
    chk1("R2 core_stall", core_stall, 1'b1);
    chk1("R2 io_hold", io_hold, 1'b1);
    tick();
    chk1("R2 wdt_clr one cycle", wdt_clr, 1'b0);

    // R4 masked flag, R9 sleep strobe while asleep
    irq_flag = 8'h02; gie = 1'b1; sleep_op = 1'b1;
    repeat (5) tick();
    sleep_op = 1'b0;
    chk1("R4 masked core_stall", core_stall, 1'b1);
    chk1("R4 masked osc_en", osc_en, 1'b0);
    chk1("R9 sleep_op asleep wdt_clr", wdt_clr, 1'b0);

    // R5 interrupt wake with gie clear (R4: gie does not block wake)
    irq_flag = 8'h01; gie = 1'b0;
    tick();
    irq_flag = 8'h00;
    chk1("R5 wdt_clr", wdt_clr, 1'b1);
    chk1("R5 osc_en", osc_en, 1'b1);
    chk1("R4 wake with gie=0", core_stall, 1'b1);
    chk1("R5 pd_bit kept", pd_bit, 1'b0);
    chk1("R5 to_bit kept", to_bit, 1'b1);
    sleep_op = 1'b1;
    repeat (SU - 1) tick();
    sleep_op = 1'b0;
    chk1("R5 still stalled", core_stall, 1'b1);
    chk1("R9 sleep_op waking", resume, 1'b0);
    tick();
    chk1("R7 stall released", core_stall, 1'b0);
    chk1("R7 resume", resume, 1'b1);
    chk1("R7 no vector gie=0", take_vector, 1'b0);
    chkw("R7 addr zero", branch_addr, '0);
    tick();
    chk1("R7 resume one cycle", resume, 1'b0);

    // R7 vectoring resume with gie set on the wake edge
    irq_en = 8'h10; sleep_op = 1'b1;
    tick();
    sleep_op = 1'b0;
    tick();
    irq_flag = 8'h10; gie = 1'b1;
    tick();
    irq_flag = 8'h00; gie = 1'b0;
    repeat (SU) tick();
    chk1("R7 vector resume", resume, 1'b1);
    chk1("R7 take_vector", take_vector, 1'b1);
    chkw("R7 branch_addr", branch_addr, VEC);

    // R3 no-op sleep right after power-on reset
    por = 1'b1;
    tick();
    por = 1'b0;
    tick();
    irq_flag = 8'h80; irq_en = 8'h80; sleep_op = 1'b1;
    tick();
    sleep_op = 1'b0; irq_flag = 8'h00;
    chk1("R3 pd_bit", pd_bit, 1'b1);
    chk1("R3 to_bit", to_bit, 1'b1);
    chk1("R3 wdt_clr", wdt_clr, 1'b0);
    chk1("R3 osc_en", osc_en, 1'b1);
    chk1("R3 core_stall", core_stall, 1'b0);

    // R6 watchdog wake
    irq_en = 8'h00; sleep_op = 1'b1;
    tick();
    sleep_op = 1'b0;
    tick();
    wdt_timeout = 1'b1; gie = 1'b1;
    tick();
    wdt_timeout = 1'b0;
    chk1("R6 to_bit cleared", to_bit, 1'b0);
    chk1("R6 wdt_clr", wdt_clr, 1'b1);
    chk1("R6 osc_en", osc_en, 1'b1);
    repeat (SU) tick();
    chk1("R6 resume", resume, 1'b1);
    chk1("R6 no vector", take_vector, 1'b0);
    gie = 1'b0;

    // R8 external reset while asleep
    sleep_op = 1'b1;
    tick();
    sleep_op = 1'b0;
    tick();
    ext_rst = 1'b1;
    tick();
    ext_rst = 1'b0;
    chk1("R8 core_stall", core_stall, 1'b0);
    chk1("R8 osc_en", osc_en, 1'b1);
    chk1("R8 pd_bit kept", pd_bit, 1'b0);
    chk1("R8 to_bit kept", to_bit, 1'b1);
    chk1("R8 no resume", resume, 1'b0);
    chk1("R8 io_hold", io_hold, 1'b0);
    tick();
    chk1("R8 stays running", core_stall, 1'b0);

    // Constrained random phase
    for (int k = 0; k < 4000; k++) begin
      sleep_op    = ($urandom % 8) == 0;
      irq_flag    = N'($urandom & $urandom & $urandom);
      irq_en      = N'($urandom);
      gie         = $urandom % 2 == 1;
      wdt_timeout = ($urandom % 24) == 0;
      ext_rst     = ($urandom % 150) == 0;
      por         = ($urandom % 1000) == 0;
      tick();
    end
    por = 1'b0; ext_rst = 1'b0; sleep_op = 1'b0; wdt_timeout = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule